// File: doc/BRIEF.md
# Two-Set Line Blink Waveform Generator

This block produces a per-line blink waveform for a bank of general-purpose I/O lines. It holds two independent waveform generators, called set A and set B. Each set has its own on-length and off-length, both counted in clock cycles. Each set emits a continuous square wave that stays high for the on-length and low for the off-length, so its period is the sum of the two.

A per-line select register assigns every line to one of the two sets. The registered output vector carries, on each bit, the waveform of the set that line has chosen. Enable gating and pad logic sit outside this block.

Software programs the block through a simple register write/read port. A length value of zero stands for the full counter range, 2^DUR_W cycles. A new length is loaded only at the next phase change, so the running phase is never cut short or stretched. Reads return the values that were written, never the live counts.

Top module: `gpio_blink_gen`

## Requirements
- R1: Word registers sit at byte addresses 0x00 (set A on-length), 0x04 (set A off-length), 0x08 (set B on-length), 0x0C (set B off-length) and 0x10 (line select). A write with `reg_wr` high stores the low DUR_W bits of the data, or the low NUM_LINES bits for the select register. A read returns that stored value, zero-extended, on `reg_rdata` one clock after the address is presented.
- R2: A write to any other address, including one whose two low address bits are not zero, changes no register. A read of such an address returns zero.
- R3: Reset clears every register to zero and starts both sets in their high phase, with `blink_out` all ones. Without writes, `blink_out` stays all ones for 2^DUR_W clock edges after reset release and is all zeros from edge 2^DUR_W+1.
- R4: Each set's waveform is high for exactly the on-length and low for exactly the off-length, in clock cycles, repeating.
- R5: A length register holding zero gives a phase of 2^DUR_W cycles.
- R6: A length written during a phase does not alter that phase. It is used from the next phase of that kind that begins after the write.
- R7: Select bit i equal to 0 routes set A to `blink_out[i]`, and 1 routes set B. The two sets run independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all lengths count its cycles |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address for write and read |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data for the address of the previous cycle |
| blink_out | output | NUM_LINES | Registered per-line blink waveform |

## Verification
The bench builds the block with DUR_W = 8 and NUM_LINES = 8. An 8-bit length makes the zero-means-full-range rule observable, since such a phase lasts 256 cycles instead of four billion. The same width makes the first phase after reset measurable to the exact edge. Eight lines keep the select register small, yet still allow mixed patterns in which the first and the last line follow different sets. Each pattern is checked by measuring high and low run lengths on those two outputs.

// File: rtl/blink_pkg.sv
package blink_pkg;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned WORD_W   = ADDR_W - 2;
  localparam int unsigned NUM_SETS = 2;

  // word indices; set B sits two words (0x8 bytes) above set A
  localparam logic [WORD_W-1:0] W_ON_BASE  = 3'd0;
  localparam logic [WORD_W-1:0] W_OFF_BASE = 3'd1;
  localparam logic [WORD_W-1:0] W_SET_STEP = 3'd2;
  localparam logic [WORD_W-1:0] W_SELECT   = 3'd4;

  typedef enum logic { SET_A = 1'b0, SET_B = 1'b1 } blink_set_e;

  function automatic logic [WORD_W-1:0] on_word(input int unsigned s);
    return W_ON_BASE + W_SET_STEP * WORD_W'(s);
  endfunction

  function automatic logic [WORD_W-1:0] off_word(input int unsigned s);
    return W_OFF_BASE + W_SET_STEP * WORD_W'(s);
  endfunction
endpackage

// File: rtl/blink_regs.sv
module blink_regs
  import blink_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DUR_W     = 32,
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [NUM_SETS-1:0][DUR_W-1:0]    on_len,
  output logic [NUM_SETS-1:0][DUR_W-1:0]    off_len,
  output logic [NUM_LINES-1:0]              line_sel,
  output logic [DATA_W-1:0]                 rdata
);
  logic              aligned;
  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] rd_next;

  assign aligned = (addr[1:0] == 2'b00);
  assign word    = addr[ADDR_W-1:2];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (rst) begin
        on_len[s]  <= '0;
        off_len[s] <= '0;
      end else if (wr && aligned) begin
        if (word == on_word(s))  on_len[s]  <= wdata[DUR_W-1:0];
        if (word == off_word(s)) off_len[s] <= wdata[DUR_W-1:0];
      end
    end

    // R1
    on_store_chk: assert property (@(posedge clk) disable iff (rst)
      (wr && aligned && word == on_word(s)) |=> (on_len[s] == $past(wdata[DUR_W-1:0])));
    // R1
    off_store_chk: assert property (@(posedge clk) disable iff (rst)
      (wr && aligned && word == off_word(s)) |=> (off_len[s] == $past(wdata[DUR_W-1:0])));
  end

  always_ff @(posedge clk) begin
    if (rst)                                     line_sel <= '0;
    else if (wr && aligned && word == W_SELECT)  line_sel <= wdata[NUM_LINES-1:0];
  end

  always_comb begin
    rd_next = '0;
    if (aligned) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        if (word == on_word(s))  rd_next[DUR_W-1:0] = on_len[s];
        if (word == off_word(s)) rd_next[DUR_W-1:0] = off_len[s];
      end
      if (word == W_SELECT) rd_next[NUM_LINES-1:0] = line_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  // R2
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (!aligned || word > W_SELECT) |=> (rdata == '0));
endmodule

// File: rtl/blink_phase_ctr.sv
module blink_phase_ctr #(
  parameter int unsigned DUR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DUR_W-1:0] on_len,
  input  logic [DUR_W-1:0] off_len,
  output logic             wave
);
  localparam logic [DUR_W-1:0] ONE = DUR_W'(1);

  logic [DUR_W-1:0] cnt_q;
  logic             phase_q;

  // cnt_q holds cycles left minus one; loading len-1 makes zero wrap to the full range
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b1;
      cnt_q   <= '1;
    end else if (cnt_q == '0) begin
      phase_q <= ~phase_q;
      cnt_q   <= (phase_q ? off_len : on_len) - ONE;
    end else begin
      cnt_q   <= cnt_q - ONE;
    end
  end

  assign wave = phase_q;

  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> $stable(phase_q));
  // R4
  phase_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0) |=> (phase_q != $past(phase_q)));
  // R6
  on_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !phase_q) |=> (cnt_q == $past(on_len) - ONE));
  // R5
  off_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && phase_q) |=> (cnt_q == $past(off_len) - ONE));
endmodule

// File: rtl/blink_line_mux.sv
module blink_line_mux
  import blink_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SETS-1:0]  waves,
  input  logic [NUM_LINES-1:0] line_sel,
  output logic [NUM_LINES-1:0] blink_q
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    blink_set_e pick;
    assign pick = blink_set_e'(line_sel[i]);
    always_ff @(posedge clk) begin
      if (rst) blink_q[i] <= 1'b1;
      else     blink_q[i] <= (pick == SET_B) ? waves[SET_B] : waves[SET_A];
    end
  end

  // R7
  all_high_chk: assert property (@(posedge clk) disable iff (rst)
    (waves == '1) |=> (blink_q == '1));
  // R7
  all_low_chk: assert property (@(posedge clk) disable iff (rst)
    (waves == '0) |=> (blink_q == '0));
endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen
  import blink_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DUR_W     = 32,
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [NUM_LINES-1:0] blink_out
);
  logic [NUM_SETS-1:0][DUR_W-1:0] on_len;
  logic [NUM_SETS-1:0][DUR_W-1:0] off_len;
  logic [NUM_LINES-1:0]           line_sel;
  logic [NUM_SETS-1:0]            waves;

  blink_regs #(.DATA_W(DATA_W), .DUR_W(DUR_W), .NUM_LINES(NUM_LINES)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .on_len(on_len), .off_len(off_len), .line_sel(line_sel), .rdata(reg_rdata)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_gen
    blink_phase_ctr #(.DUR_W(DUR_W)) u_ctr (
      .clk(clk), .rst(rst), .on_len(on_len[s]), .off_len(off_len[s]), .wave(waves[s])
    );
  end

  blink_line_mux #(.NUM_LINES(NUM_LINES)) u_mux (
    .clk(clk), .rst(rst), .waves(waves), .line_sel(line_sel), .blink_q(blink_out)
  );
endmodule

// File: tb/gpio_blink_gen_tb.sv
module gpio_blink_gen_tb;
  localparam int DATA_W = 32;
  localparam int DUR_W  = 8;
  localparam int NL     = 8;
  localparam int FULL   = 1 << DUR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0;
  logic [4:0]        reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [NL-1:0]     blink_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  gpio_blink_gen #(.DATA_W(DATA_W), .DUR_W(DUR_W), .NUM_LINES(NL)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .blink_out(blink_out)
  );

  // fields: a_on, a_off, b_on, b_off, select
  localparam logic [39:0] VECS [5] = '{
    {8'd3, 8'd5, 8'd7, 8'd2, 8'h80},
    {8'd1, 8'd1, 8'd4, 8'd6, 8'h01},
    {8'd9, 8'd2, 8'd1, 8'd1, 8'hFF},
    {8'd0, 8'd3, 8'd2, 8'd0, 8'h7E},
    {8'd6, 8'd6, 8'd6, 8'd6, 8'h00}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output int d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = int'(reg_rdata);
  endtask

  task automatic measure(input int line, output int hi, output int lo);
    @(negedge clk);
    while (blink_out[line])  @(negedge clk);
    while (!blink_out[line]) @(negedge clk);
    hi = 0;
    while (blink_out[line])  begin hi++; @(negedge clk); end
    lo = 0;
    while (!blink_out[line]) begin lo++; @(negedge clk); end
  endtask

  function automatic int eff(input logic [7:0] v);
    return (v == 8'd0) ? FULL : int'(v);
  endfunction

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int v, hi, lo;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R3: reset phase length of the full range
    check("R3", "blink_out at release", int'(blink_out), 8'hFF);
    repeat (FULL) @(negedge clk);
    check("R3", "blink_out at edge 256", int'(blink_out), 8'hFF);
    @(negedge clk);
    check("R3", "blink_out at edge 257", int'(blink_out), 8'h00);
    for (int a = 0; a < 5; a++) begin
      rd(5'(a * 4), v);
      check("R3", "register reset value", v, 0);
    end

    // R1: readback, truncation to DUR_W and NUM_LINES
    wr(5'h00, 32'h1234_5677);
    wr(5'h04, 32'h0000_0011);
    wr(5'h08, 32'h0000_00A5);
    wr(5'h0C, 32'hFFFF_FF3C);
    wr(5'h10, 32'h0000_0F5A);
    rd(5'h00, v); check("R1", "A on readback", v, 32'h77);
    rd(5'h04, v); check("R1", "A off readback", v, 32'h11);
    rd(5'h08, v); check("R1", "B on readback", v, 32'hA5);
    rd(5'h0C, v); check("R1", "B off readback", v, 32'h3C);
    rd(5'h10, v); check("R1", "select readback", v, 32'h5A);

    // R2: unmapped and misaligned writes change nothing, read zero
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h01, 32'hFFFF_FFFF);
    wr(5'h12, 32'h0000_0000);
    rd(5'h14, v); check("R2", "unmapped read", v, 0);
    rd(5'h01, v); check("R2", "misaligned read", v, 0);
    rd(5'h00, v); check("R2", "A on after stray writes", v, 32'h77);
    rd(5'h10, v); check("R2", "select after stray writes", v, 32'h5A);

    // R4 R5 R7: table of waveform patterns
    for (int k = 0; k < 5; k++) begin
      logic [39:0] e;
      int a_hi, a_lo, b_hi, b_lo;
      e = VECS[k];
      wr(5'h00, {24'd0, e[39:32]});
      wr(5'h04, {24'd0, e[31:24]});
      wr(5'h08, {24'd0, e[23:16]});
      wr(5'h0C, {24'd0, e[15:8]});
      wr(5'h10, {24'd0, e[7:0]});
      a_hi = eff(e[39:32]); a_lo = eff(e[31:24]);
      b_hi = eff(e[23:16]); b_lo = eff(e[15:8]);
      measure(0, hi, lo);
      check("R4 R5 R7", "line 0 high run", hi, e[0] ? b_hi : a_hi);
      check("R4 R5 R7", "line 0 low run",  lo, e[0] ? b_lo : a_lo);
      measure(NL - 1, hi, lo);
      check("R4 R5 R7", "line 7 high run", hi, e[NL-1] ? b_hi : a_hi);
      check("R4 R5 R7", "line 7 low run",  lo, e[NL-1] ? b_lo : a_lo);
    end

    // R6: a write during the on phase waits for the next on phase
    wr(5'h10, 32'h0);
    wr(5'h00, 32'd200);
    wr(5'h04, 32'd200);
    @(negedge clk);
    while (blink_out[0])  @(negedge clk);
    while (!blink_out[0]) @(negedge clk);
    while (!blink_out[0]) @(negedge clk);
    while (blink_out[0])  @(negedge clk);
    while (!blink_out[0]) @(negedge clk);
    hi = 0;
    while (blink_out[0]) begin
      hi++;
      if (hi == 10) begin reg_wr = 1'b1; reg_addr = 5'h00; reg_wdata = 32'd4; end
      else reg_wr = 1'b0;
      @(negedge clk);
    end
    reg_wr = 1'b0;
    check("R6", "current on phase kept", hi, 200);
    lo = 0;
    while (!blink_out[0]) begin lo++; @(negedge clk); end
    check("R6", "off phase unchanged", lo, 200);
    hi = 0;
    while (blink_out[0]) begin hi++; @(negedge clk); end
    check("R6", "next on phase uses new length", hi, 4);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule